// File: doc/BRIEF.md
# Four-Lane Card Block Writer

This block sends a run of fixed-size data blocks to a memory card over a four-bit data bus. For every block it drives all lanes high for one cycle and then a start nibble of zeros. It then shifts out the payload one nibble per cycle, taken from a 32-bit word stream. After the payload it sends a 16-bit CRC for each lane and one all-ones end nibble, and then releases the bus.

Once the bus is released, the writer watches lane 0 for the card's write-status token. A token is found by its leading zero bit, and the three bits that follow it form the status code. When the card accepts the block, the writer waits while the card holds lane 0 low (busy), counts the block, and starts the next one. Any other code ends the transfer at once with an error status. An overall cycle budget, set at the port, aborts a stalled transfer.

One bus bit time is one clock cycle of this block. The word source must have the next word ready whenever the writer raises its consume strobe.

Top module: `sdw_block_writer`

## Requirements
- R1: Each block begins with one cycle in which dat_oe is 1 and dat_out is 4'hF, followed by one cycle in which dat_oe is 1 and dat_out is 4'h0 (the start nibble).
- R2: The payload follows the start nibble as BLOCK_BYTES*2 consecutive nibbles. Each word goes out from bits [31:28] down to bits [3:0], with dat_out[i] carrying lane i. wready is high for exactly one cycle per word, and wdata is taken at the clock edge that ends that cycle.
- R3: After the payload, lane i carries its own CRC-16 for 16 cycles, most significant bit first. The CRC uses polynomial x^16+x^12+x^5+1 with an initial value of 0 and covers lane i's payload bits only. One cycle of dat_out = 4'hF follows, and dat_oe then drops to 0.
- R4: After the bus is released, dat0_in is sampled for up to 31 cycles looking for a 0 start bit. The next three samples, first one most significant, form the status code. If no start bit appears within the window, the transfer ends with status 2.
- R5: Status encoding is 0 for success, 1 for a card CRC error, 2 for a write failure and 3 for a timeout. Code 3'b010 means the block was accepted. Code 3'b101 gives status 1. Code 3'b110 and every other code give status 2. The status holds until the next accepted start.
- R6: A code other than 3'b010 ends the transfer in the cycle after the status bits. busy falls, done pulses for one cycle, blocks_done keeps its value, and no further block is driven.
- R7: After an accepted code, the writer does not drive the bus while dat0_in is low. On the first cycle in which dat0_in is high, blocks_done increments. The writer then starts the next block, or, if that was the last block, ends the transfer with status 0.
- R8: When the number of cycles since the start reaches timeout_limit, the transfer is aborted with status 3 and the bus is released.
- R9: A start with block_count = 0 produces a done pulse in the next cycle with status 0, and the bus is never driven.
- R10: A start pulse while busy is high is ignored. The running transfer keeps its block count.
- R11: After reset: dat_oe, busy, done and wready are 0, blocks_done is 0 and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| block_count | input | CNT_W | Number of blocks to write, latched at start |
| timeout_limit | input | TO_W | Cycle budget for the whole transfer |
| wdata | input | WORD_W | Current payload word from the stream |
| wready | output | 1 | Word consumed at the end of this cycle |
| dat_out | output | 4 | Lane drive values, bit i is lane i |
| dat_oe | output | 1 | Drive enable for all four lanes |
| dat0_in | input | 1 | Sampled level of lane 0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| status | output | 2 | Result of the last transfer (R5 encoding) |
| blocks_done | output | CNT_W | Blocks accepted in the current or last transfer |

## Verification
The bench plays the card. It recomputes every payload nibble and each lane's CRC from the word pattern, and it answers with tokens whose start bit comes after gaps of various lengths. If the design got the nibble order or lane mapping wrong, the payload or CRC comparison would fail. The bench sends the 101, 110, 111 and 000 codes. A decoder that treated any non-010 code as success would chain a further block, and one that mapped codes wrongly would report the wrong status. Busy periods of several lengths catch a writer that restarts while lane 0 is still low. A gap longer than the search window catches a writer that waits forever. A busy period that never ends catches a missing timeout. The bench also covers a zero block count and a start pulse that arrives mid-transfer.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_CRC_ERR = 2'd1,
    ST_WR_FAIL = 2'd2,
    ST_TIMEOUT = 2'd3
  } wr_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_STRT,
    PH_DATA,
    PH_CRC,
    PH_ENDB,
    PH_RESP,
    PH_BUSY
  } phase_e;

  localparam logic [2:0] TOK_ACCEPT = 3'b010;
  localparam logic [2:0] TOK_CRCERR = 3'b101;
  localparam int unsigned CRC_BITS  = 16;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

endpackage

// File: rtl/sdw_crc_lanes.sv
module sdw_crc_lanes #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             shift,
  input  logic [LANES-1:0] nib,
  output logic [LANES-1:0] msb
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CRC_W-1:0] crc_q, crc_d;
    logic             fb;

    always_comb begin
      fb    = nib[l] ^ crc_q[CRC_W-1];
      crc_d = crc_q;
      if (clr)
        crc_d = '0;
      else if (adv)
        crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
      else if (shift)
        crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        crc_q <= '0;
      else if (clr || adv || shift)
        crc_q <= crc_d;
    end

    assign msb[l] = crc_q[CRC_W-1];
  end

  // R3: accumulate, emit and clear never overlap
  a_r3_one_crc_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr, adv, shift}));

endmodule

// File: rtl/sdw_token_rx.sv
module sdw_token_rx #(
  parameter int unsigned RESP_WIN = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       dat0,
  output logic       tok_valid,
  output logic       tok_missing,
  output logic [2:0] tok_code
);

  localparam int unsigned WIN_W = $clog2(RESP_WIN + 1);

  logic             srch_q, srch_d;
  logic             coll_q, coll_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [1:0]       bitc_q, bitc_d;
  logic [2:0]       code_q, code_d;
  logic             val_q, val_d;
  logic             miss_q, miss_d;

  always_comb begin
    srch_d = srch_q;
    coll_d = coll_q;
    win_d  = win_q;
    bitc_d = bitc_q;
    code_d = code_q;
    val_d  = 1'b0;
    miss_d = 1'b0;
    if (arm) begin
      srch_d = 1'b1;
      coll_d = 1'b0;
      win_d  = '0;
    end else if (srch_q) begin
      if (!dat0) begin
        srch_d = 1'b0;
        coll_d = 1'b1;
        bitc_d = '0;
      end else if (win_q == WIN_W'(RESP_WIN - 1)) begin
        srch_d = 1'b0;
        miss_d = 1'b1;
      end else begin
        win_d = win_q + WIN_W'(1);
      end
    end else if (coll_q) begin
      code_d = {code_q[1:0], dat0};
      bitc_d = bitc_q + 2'd1;
      if (bitc_q == 2'd2) begin
        coll_d = 1'b0;
        val_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_q <= 1'b0;
      coll_q <= 1'b0;
      win_q  <= '0;
      bitc_q <= '0;
      code_q <= '0;
      val_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      srch_q <= srch_d;
      coll_q <= coll_d;
      win_q  <= win_d;
      bitc_q <= bitc_d;
      code_q <= code_d;
      val_q  <= val_d;
      miss_q <= miss_d;
    end
  end

  assign tok_valid   = val_q;
  assign tok_missing = miss_q;
  assign tok_code    = code_q;

  // R4: a search ends in either a code or a missing token, never both
  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_valid, tok_missing}));

  // R4: searching and collecting are exclusive phases
  a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(srch_q && coll_q));

endmodule

// File: rtl/sdw_block_writer.sv
module sdw_block_writer
  import sdw_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 512,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TO_W        = 24,
  parameter int unsigned RESP_WIN    = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  block_count,
  input  logic [TO_W-1:0]   timeout_limit,
  input  logic [WORD_W-1:0] wdata,
  output logic              wready,
  output logic [3:0]        dat_out,
  output logic              dat_oe,
  input  logic              dat0_in,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  blocks_done
);

  localparam int unsigned LANES   = 4;
  localparam int unsigned NIBBLES = BLOCK_BYTES * 2;
  localparam int unsigned NIB_W   = $clog2(NIBBLES);
  localparam int unsigned NPW     = WORD_W / LANES;
  localparam int unsigned NPW_W   = $clog2(NPW);

  phase_e            state_q, state_d;
  logic [NIB_W-1:0]  nib_q, nib_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  nblk_q, nblk_d;
  logic [CNT_W-1:0]  bdone_q, bdone_d;
  logic [TO_W-1:0]   timer_q, timer_d;
  wr_status_e        stat_q, stat_d;
  logic              done_q, done_d;
  logic              shreg_en;

  logic              tok_valid, tok_missing;
  logic [2:0]        tok_code;
  logic [LANES-1:0]  crc_msb;
  logic              active;
  logic              word_last;

  assign active    = (state_q != PH_IDLE);
  assign word_last = (nib_q[NPW_W-1:0] == '1);

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d  = state_q;
    nib_d    = nib_q;
    shreg_d  = shreg_q;
    shreg_en = 1'b0;
    nblk_d   = nblk_q;
    bdone_d  = bdone_q;
    timer_d  = timer_q;
    stat_d   = stat_q;
    done_d   = 1'b0;
    wready   = 1'b0;

    if (active)
      timer_d = timer_q + TO_W'(1);

    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          nblk_d  = block_count;
          bdone_d = '0;
          timer_d = '0;
          stat_d  = ST_OK;
          if (block_count == '0)
            done_d = 1'b1;
          else
            state_d = PH_PRE;
        end
      end
      PH_PRE: state_d = PH_STRT;
      PH_STRT: begin
        wready   = 1'b1;
        shreg_en = 1'b1;
        shreg_d  = wdata;
        nib_d    = '0;
        state_d  = PH_DATA;
      end
      PH_DATA: begin
        shreg_en = 1'b1;
        shreg_d  = {shreg_q[WORD_W-LANES-1:0], {LANES{1'b0}}};
        nib_d    = nib_q + NIB_W'(1);
        if (nib_q == NIB_W'(NIBBLES - 1)) begin
          nib_d   = '0;
          state_d = PH_CRC;
        end else if (word_last) begin
          wready  = 1'b1;
          shreg_d = wdata;
        end
      end
      PH_CRC: begin
        nib_d = nib_q + NIB_W'(1);
        if (nib_q == NIB_W'(CRC_BITS - 1))
          state_d = PH_ENDB;
      end
      PH_ENDB: state_d = PH_RESP;
      PH_RESP: begin
        if (tok_missing) begin
          state_d = PH_IDLE;
          stat_d  = ST_WR_FAIL;
          done_d  = 1'b1;
        end else if (tok_valid) begin
          if (tok_code == TOK_ACCEPT) begin
            state_d = PH_BUSY;
          end else begin
            state_d = PH_IDLE;
            stat_d  = (tok_code == TOK_CRCERR) ? ST_CRC_ERR : ST_WR_FAIL;
            done_d  = 1'b1;
          end
        end
      end
      PH_BUSY: begin
        if (dat0_in) begin
          bdone_d = bdone_q + CNT_W'(1);
          if (bdone_q + CNT_W'(1) == nblk_q) begin
            state_d = PH_IDLE;
            stat_d  = ST_OK;
            done_d  = 1'b1;
          end else begin
            state_d = PH_PRE;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase

    // overall budget overrides any phase result
    if (active && (timer_q >= timeout_limit)) begin
      state_d = PH_IDLE;
      stat_d  = ST_TIMEOUT;
      done_d  = 1'b1;
      bdone_d = bdone_q;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      nib_q   <= '0;
      nblk_q  <= '0;
      bdone_q <= '0;
      timer_q <= '0;
      stat_q  <= ST_OK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nib_q   <= nib_d;
      nblk_q  <= nblk_d;
      bdone_q <= bdone_d;
      timer_q <= timer_d;
      stat_q  <= stat_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg_q <= '0;
    else if (shreg_en)
      shreg_q <= shreg_d;
  end

  // ---------------- sub-blocks ----------------
  sdw_crc_lanes #(
    .LANES (LANES),
    .CRC_W (CRC_BITS),
    .POLY  (CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == PH_PRE),
    .adv   (state_q == PH_DATA),
    .shift (state_q == PH_CRC),
    .nib   (shreg_q[WORD_W-1 -: LANES]),
    .msb   (crc_msb)
  );

  sdw_token_rx #(
    .RESP_WIN (RESP_WIN)
  ) u_tok (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (state_q == PH_ENDB),
    .dat0        (dat0_in),
    .tok_valid   (tok_valid),
    .tok_missing (tok_missing),
    .tok_code    (tok_code)
  );

  // ---------------- outputs ----------------
  always_comb begin
    dat_oe  = 1'b0;
    dat_out = 4'hF;
    unique case (state_q)
      PH_PRE:  dat_oe = 1'b1;
      PH_STRT: begin dat_oe = 1'b1; dat_out = 4'h0; end
      PH_DATA: begin dat_oe = 1'b1; dat_out = shreg_q[WORD_W-1 -: LANES]; end
      PH_CRC:  begin dat_oe = 1'b1; dat_out = crc_msb; end
      PH_ENDB: dat_oe = 1'b1;
      default: ;
    endcase
  end

  assign busy        = active;
  assign done        = done_q;
  assign status      = stat_q;
  assign blocks_done = bdone_q;

  // ---------------- assertions ----------------
  // R2: words are consumed only while the bus is being driven
  a_r2_wready_driving: assert property (@(posedge clk) disable iff (!rst_n)
    wready |-> dat_oe);

  // R6: a rejected token ends the transfer in the next cycle
  a_r6_stop_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RESP && tok_valid && tok_code != TOK_ACCEPT) |=> (!busy && done));

  // R7: no drive while the card holds lane 0 low
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_BUSY && !dat0_in) |=> !dat_oe);

  // R7: the block counter steps by at most one per cycle
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (blocks_done == $past(blocks_done) || blocks_done == $past(blocks_done) + CNT_W'(1)));

  // R10: a running transfer never counts past its latched block count
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blocks_done < nblk_q));

endmodule

// File: tb/sdw_block_writer_tb_top.sv
`timescale 1ns/1ps
module sdw_block_writer_tb_top;

  localparam int NIB  = 1024;
  localparam int WPB  = 128;

  typedef struct packed {
    logic [3:0] nblk;
    logic [3:0] bad;
    logic [2:0] code;
    logic [7:0] gap;
    logic [7:0] bsy;
    logic [1:0] est;
    logic [3:0] edn;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd1, 4'd15, 3'b010, 8'd2,  8'd5,  2'd0, 4'd1},
    '{4'd3, 4'd15, 3'b010, 8'd0,  8'd0,  2'd0, 4'd3},
    '{4'd3, 4'd1,  3'b101, 8'd3,  8'd1,  2'd1, 4'd1},
    '{4'd2, 4'd0,  3'b110, 8'd1,  8'd0,  2'd2, 4'd0},
    '{4'd2, 4'd1,  3'b111, 8'd0,  8'd2,  2'd2, 4'd1},
    '{4'd1, 4'd0,  3'b000, 8'd4,  8'd0,  2'd2, 4'd0},
    '{4'd2, 4'd15, 3'b010, 8'd20, 8'd40, 2'd0, 4'd2},
    '{4'd1, 4'd15, 3'b010, 8'd40, 8'd0,  2'd2, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] block_count;
  logic [23:0] timeout_limit;
  logic [31:0] wdata;
  logic        wready;
  logic [3:0]  dat_out;
  logic        dat_oe;
  logic        dat0_in;
  logic        busy;
  logic        done;
  logic [1:0]  status;
  logic [15:0] blocks_done;

  logic        src_clr;
  logic [31:0] seed;
  int          gidx;
  int          done_cnt;
  int          tests = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  sdw_block_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .block_count(block_count),
    .timeout_limit(timeout_limit), .wdata(wdata), .wready(wready),
    .dat_out(dat_out), .dat_oe(dat_oe), .dat0_in(dat0_in), .busy(busy),
    .done(done), .status(status), .blocks_done(blocks_done)
  );

  function automatic logic [31:0] pat(input int i, input logic [31:0] s);
    logic [31:0] u;
    u = 32'(i);
    return (u * 32'h9E3779B9) ^ {u[15:0], ~u[15:0]} ^ s;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  assign wdata = pat(gidx, seed);

  always @(posedge clk) begin
    if (src_clr) gidx <= 0;
    else if (wready) gidx <= gidx + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) done_cnt <= 0;
    else if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Card model for one block: checks the frame, answers with a token.
  task automatic card_block(input int blk, input logic [2:0] code, input int gap, input int bsy);
    logic        prev_hi;
    logic [15:0] c [4];
    int          bad;
    int          waitc;
    logic [31:0] w;
    logic [3:0]  en;
    for (int l = 0; l < 4; l++) c[l] = 16'h0;
    prev_hi = dat_oe && (dat_out == 4'hF);
    waitc = 0;
    forever begin
      @(negedge clk);
      if (dat_oe && dat_out == 4'h0) break;
      prev_hi = dat_oe && (dat_out == 4'hF);
      waitc++;
      if (waitc > 4000) begin
        chk(1'b0, "R1 start nibble never seen", 0, 1);
        return;
      end
    end
    chk(prev_hi, "R1 lanes high before start", prev_hi, 1);
    bad = 0;
    for (int n = 0; n < NIB; n++) begin
      @(negedge clk);
      w  = pat(blk * WPB + n / 8, seed);
      en = 4'(w >> (28 - 4 * (n % 8)));
      if (!dat_oe || dat_out != en) bad++;
      for (int l = 0; l < 4; l++) c[l] = crc_step(c[l], dat_out[l]);
    end
    chk(bad == 0, "R2 payload nibbles", bad, 0);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      en = {c[3][15-k], c[2][15-k], c[1][15-k], c[0][15-k]};
      if (!dat_oe || dat_out != en) bad++;
    end
    chk(bad == 0, "R3 per-lane CRC", bad, 0);
    @(negedge clk);
    chk(dat_oe && dat_out == 4'hF, "R3 end nibble", {dat_oe, dat_out}, 5'h1F);
    @(negedge clk);
    chk(!dat_oe, "R3 bus released", dat_oe, 0);
    repeat (gap) begin dat0_in = 1'b1; @(negedge clk); end
    dat0_in = 1'b0; @(negedge clk);
    dat0_in = code[2]; @(negedge clk);
    dat0_in = code[1]; @(negedge clk);
    dat0_in = code[0]; @(negedge clk);
    dat0_in = 1'b1;
    if (code == 3'b010) begin
      bad = 0;
      repeat (bsy) begin
        @(negedge clk);
        if (dat_oe) bad++;
        dat0_in = 1'b0;
      end
      @(negedge clk);
      if (dat_oe) bad++;
      dat0_in = 1'b1;
      chk(bad == 0, "R7 no drive during card busy", bad, 0);
    end
  endtask

  task automatic kick(input int nblk, input logic [31:0] s);
    @(negedge clk);
    src_clr = 1'b1;
    seed    = s;
    @(negedge clk);
    src_clr     = 1'b0;
    block_count = 16'(nblk);
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int k;
    k = 0;
    while (busy && k < lim) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0;
    logic stopped;
    rst_n = 1'b0; start = 1'b0; block_count = '0; timeout_limit = 24'd100000;
    dat0_in = 1'b1; src_clr = 1'b1; seed = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!dat_oe && !busy && !done && !wready, "R11 reset controls", {dat_oe, busy, done, wready}, 0);
    chk(blocks_done == 0 && status == 2'd0, "R11 reset count/status", {blocks_done, status}, 0);

    // R9 zero blocks
    block_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy && !dat_oe, "R9 zero-block done", {done, busy, dat_oe}, 3'b100);
    chk(status == 2'd0, "R9 zero-block status", status, 0);
    @(negedge clk);
    chk(!done && !dat_oe, "R9 single done pulse", {done, dat_oe}, 0);

    // Vector walk: R1-R7
    for (int v = 0; v < 8; v++) begin
      d0 = done_cnt;
      kick(int'(VEC[v].nblk), 32'h1234_0000 + 32'(v));
      stopped = 1'b0;
      for (int b = 0; b < int'(VEC[v].nblk); b++) begin
        logic [2:0] cd;
        cd = (b == int'(VEC[v].bad)) ? VEC[v].code : 3'b010;
        card_block(b, cd, int'(VEC[v].gap), int'(VEC[v].bsy));
        if (cd != 3'b010) begin
          @(negedge clk);
          chk(!busy && !dat_oe, "R6 immediate stop", {busy, dat_oe}, 0);
          stopped = 1'b1;
          break;
        end
      end
      wait_idle(200);
      chk(!busy, "R7 transfer finished", busy, 0);
      chk(done_cnt == d0 + 1, "R6 R7 one done pulse", done_cnt - d0, 1);
      chk(status == VEC[v].est, "R4 R5 status code", status, VEC[v].est);
      chk(blocks_done == 16'(VEC[v].edn), "R6 R7 blocks_done", blocks_done, VEC[v].edn);
      if (stopped) chk(!dat_oe, "R6 no further block", dat_oe, 0);
    end

    // R10 start ignored while busy
    kick(1, 32'hCAFE_0001);
    fork
      card_block(0, 3'b010, 1, 3);
      begin
        repeat (60) @(negedge clk);
        block_count = 16'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    wait_idle(200);
    chk(blocks_done == 16'd1 && status == 2'd0, "R10 start while busy ignored", blocks_done, 1);
    repeat (20) @(negedge clk);
    chk(!busy && !dat_oe, "R10 no restart", {busy, dat_oe}, 0);

    // R8 timeout while the card stays busy
    timeout_limit = 24'd1500;
    kick(1, 32'hBEEF_0002);
    card_block(0, 3'b010, 0, 1600);
    chk(!busy && !dat_oe, "R8 aborted and released", {busy, dat_oe}, 0);
    chk(status == 2'd3, "R8 timeout status", status, 3);
    chk(blocks_done == 16'd0, "R8 no block counted", blocks_done, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule